// File: doc/BRIEF.md
# Parallel I/O Line Controller with Filtered Input Interrupts

This block controls a bank of up to 32 I/O lines. Each line is either a general-purpose I/O, driven from its own output-value and output-enable bits, or handed to one of four peripheral functions, which then drive the pad. Every configuration bit sits in a register group that has a set address and a clear address. Writing 1 to a bit sets or clears that bit, and writing 0 leaves it alone. Software therefore never needs a read-modify-write to change one line.

On the input side, every pad passes through a two-flop synchronizer and then an optional filter. The filter is chosen per line: a glitch filter, or a debouncer timed by a shared programmable divider. The filtered level feeds four consumers:
- the pin-data register;
- the peripherals;
- the per-line interrupt detector, which can trigger on any change, a rising edge, a falling edge, a low level or a high level;
- a clear-on-read status register, which is combined with a mask to drive one interrupt output.

Top module: `pio_bank`

## Requirements
- R1: Register addresses are {group[3:0], op[1:0]}, with op 0 = set, 1 = clear, 2 = read value. The groups are: 0 output value, 1 output enable, 2 GPIO select, 3 function-select bit 0, 4 function-select bit 1, 5 filter enable, 6 filter kind (1 = debounce, 0 = glitch), 7 interrupt mask, 8 trigger qualify, 9 trigger level, 10 trigger polarity. A 1 in write data sets (op 0) or clears (op 1) that bit, and a 0 leaves it unchanged. Reads return data one cycle after `rd_en`.
- R2: After reset, the output value, output enable, mask and status registers read 0, the GPIO select group reads all ones, and `irq` is 0.
- R3: A line whose GPIO-select bit is 1 drives `pad_out` and `pad_oe` from its output-value and output-enable bits.
- R4: A line whose GPIO-select bit is 0 takes `pad_out` and `pad_oe` from peripheral function k = {sel1, sel0}. That is bit k*N+i of `per_out`/`per_oe` for line i.
- R5: Address 44 reads the filtered input level of every line, whatever drives the pad. With filtering off, it follows `pad_in` after the two-flop synchronizer.
- R6: With the glitch filter selected, a new level is accepted only after two consecutive equal synchronized samples. A one-cycle pulse never reaches pin data or the status register.
- R7: With the debouncer selected, a new level is accepted only after it has held for DB_TICKS divider periods. The divider period is (value written at address 46) + 1 cycles. Shorter pulses are rejected.
- R8: Trigger qualify = 0 selects any-change detection: both edges latch the status bit.
- R9: Qualify = 1, level = 0 selects edge detection. Polarity 1 latches only rising edges and polarity 0 only falling edges, once per edge.
- R10: Qualify = 1, level = 1 selects level detection. Polarity 1 means high and 0 means low, and the status bit is latched again every cycle the level holds.
- R11: Reading the status register (address 45) returns the latched events and clears them. Events arriving in the same cycle stay latched.
- R12: `irq` is high while any status bit has its mask bit set. Masked-off lines still latch status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address {group, op} |
| wr_data | input | N | Write data (bit mask for set/clear) |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Read address |
| rd_data | output | N | Read data, valid the cycle after rd_en |
| pad_in | input | N | Raw pad input levels |
| pad_out | output | N | Pad output value |
| pad_oe | output | N | Pad output enable |
| per_out | input | 4*N | Peripheral output values, function k in bits k*N+: N |
| per_oe | input | 4*N | Peripheral output enables, same layout |
| per_in | output | N | Filtered input levels given to the peripherals |
| irq | output | 1 | Combined masked interrupt |

## Verification
A wrong set/clear bit appears on `pad_out` or `pad_oe` in the very next cycle and in the read-back one cycle after a read. A wrong function-select code shows at once as a pad copying the wrong `per_out` lane. A faulty filter or detector state shows up within a few cycles of a pad transition, as a status bit that should stay 0, or a missing one. The status bit is read after a fixed settle window, and `irq` is watched before and after the clearing read. Level triggers are told apart from edge triggers by a second read, which must show the bit again only for level modes.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int ADDR_W = 6;

    // register groups, each with set / clear / value ops
    localparam int GRP_OUT  = 0;
    localparam int GRP_OE   = 1;
    localparam int GRP_GPIO = 2;
    localparam int GRP_SEL0 = 3;
    localparam int GRP_SEL1 = 4;
    localparam int GRP_FEN  = 5;
    localparam int GRP_FDB  = 6;
    localparam int GRP_MASK = 7;
    localparam int GRP_ALT  = 8;
    localparam int GRP_LVL  = 9;
    localparam int GRP_POL  = 10;
    localparam int NGRP     = 11;
    localparam int GRP_STAT = 11;

    localparam logic [ADDR_W-1:0] A_PIN = 6'd44;
    localparam logic [ADDR_W-1:0] A_ISR = 6'd45;
    localparam logic [ADDR_W-1:0] A_DIV = 6'd46;

    typedef enum logic [1:0] {OP_SET = 2'd0, OP_CLR = 2'd1, OP_VAL = 2'd2, OP_AUX = 2'd3} op_e;

    typedef struct packed {
        logic [3:0] grp;
        op_e        op;
    } addr_t;

    typedef enum logic [2:0] {TRG_ANY, TRG_RISE, TRG_FALL, TRG_LOW, TRG_HIGH} trig_e;

    function automatic trig_e trig_decode(input logic alt, input logic lvl, input logic pol);
        if (!alt)      return TRG_ANY;
        else if (!lvl) return pol ? TRG_RISE : TRG_FALL;
        else           return pol ? TRG_HIGH : TRG_LOW;
    endfunction

    function automatic logic trig_event(input trig_e k, input logic cur, input logic prev);
        case (k)
            TRG_ANY:  return cur ^ prev;
            TRG_RISE: return cur & ~prev;
            TRG_FALL: return ~cur & prev;
            TRG_LOW:  return ~cur;
            TRG_HIGH: return cur;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pio_setclr_bank.sv
module pio_setclr_bank
    import pio_pkg::*;
#(
    parameter int N = 32,
    parameter int G = NGRP,
    parameter logic [G-1:0] ONES_AT_RESET = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  addr_t               wr_addr,
    input  logic [N-1:0]        wr_data,
    output logic [G-1:0][N-1:0] q
);
    for (genvar g = 0; g < G; g++) begin : g_grp
        logic hit;
        assign hit = wr_en && (wr_addr.grp == 4'(g));
        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= {N{ONES_AT_RESET[g]}};
            else if (hit && wr_addr.op == OP_SET)
                q[g] <= q[g] | wr_data;
            else if (hit && wr_addr.op == OP_CLR)
                q[g] <= q[g] & ~wr_data;
        end
    end
endmodule

// File: rtl/pio_in_filter.sv
module pio_in_filter #(
    parameter int N        = 32,
    parameter int DIVW     = 16,
    parameter int DB_TICKS = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    pad_in,
    input  logic [N-1:0]    flt_en,
    input  logic [N-1:0]    flt_db,
    input  logic [DIVW-1:0] div_val,
    output logic [N-1:0]    filt
);
    localparam int CW = $clog2(DB_TICKS + 1);

    logic [N-1:0]    sync1, sync2;
    logic [DIVW-1:0] div_cnt;
    logic            tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '0;
            sync2 <= '0;
        end else begin
            sync1 <= pad_in;
            sync2 <= sync1;
        end
    end

    // shared slow-clock divider for the debouncers
    assign tick = (div_cnt == div_val);
    always_ff @(posedge clk) begin
        if (rst || tick) div_cnt <= '0;
        else             div_cnt <= div_cnt + 1'b1;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        logic          prev_s, glitch_q, deb_q;
        logic [CW-1:0] stable_cnt;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_s   <= 1'b0;
                glitch_q <= 1'b0;
            end else begin
                prev_s <= sync2[i];
                if (sync2[i] == prev_s) glitch_q <= sync2[i];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                deb_q      <= 1'b0;
                stable_cnt <= '0;
            end else if (sync2[i] == deb_q) begin
                stable_cnt <= '0;
            end else if (tick) begin
                if (stable_cnt == CW'(DB_TICKS - 1)) begin
                    deb_q      <= sync2[i];
                    stable_cnt <= '0;
                end else begin
                    stable_cnt <= stable_cnt + 1'b1;
                end
            end
        end

        always_comb begin
            if (!flt_en[i])     filt[i] = sync2[i];
            else if (flt_db[i]) filt[i] = deb_q;
            else                filt[i] = glitch_q;
        end
    end
endmodule

// File: rtl/pio_irq.sv
module pio_irq
    import pio_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] filt,
    input  logic [N-1:0] alt,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] pol,
    input  logic         clr_rd,
    output logic [N-1:0] isr
);
    logic [N-1:0] prev, ev;

    for (genvar i = 0; i < N; i++) begin : g_det
        trig_e kind;
        assign kind  = trig_decode(alt[i], lvl[i], pol[i]);
        assign ev[i] = trig_event(kind, filt[i], prev[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            isr  <= '0;
        end else begin
            prev <= filt;
            isr  <= (clr_rd ? '0 : isr) | ev;
        end
    end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter int N        = 32,
    parameter int DIVW     = 16,
    parameter int DB_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N-1:0]      wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [N-1:0]      rd_data,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_oe,
    input  logic [4*N-1:0]    per_out,
    input  logic [4*N-1:0]    per_oe,
    output logic [N-1:0]      per_in,
    output logic              irq
);
    localparam logic [NGRP-1:0] ONES = NGRP'(1) << GRP_GPIO;

    logic [NGRP-1:0][N-1:0] cfg;
    logic [N-1:0]           out_q, gpio_q, isr_q, filt;
    logic [DIVW-1:0]        div_q;
    logic                   clr_rd;
    addr_t                  ra;

    pio_setclr_bank #(.N(N), .G(NGRP), .ONES_AT_RESET(ONES)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(addr_t'(wr_addr)),
        .wr_data(wr_data),
        .q      (cfg)
    );

    assign out_q  = cfg[GRP_OUT];
    assign gpio_q = cfg[GRP_GPIO];

    always_ff @(posedge clk) begin
        if (rst)                              div_q <= '0;
        else if (wr_en && wr_addr == A_DIV)   div_q <= DIVW'(wr_data);
    end

    pio_in_filter #(.N(N), .DIVW(DIVW), .DB_TICKS(DB_TICKS)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .flt_en (cfg[GRP_FEN]),
        .flt_db (cfg[GRP_FDB]),
        .div_val(div_q),
        .filt   (filt)
    );

    assign clr_rd = rd_en && (rd_addr == A_ISR);

    pio_irq #(.N(N)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .filt  (filt),
        .alt   (cfg[GRP_ALT]),
        .lvl   (cfg[GRP_LVL]),
        .pol   (cfg[GRP_POL]),
        .clr_rd(clr_rd),
        .isr   (isr_q)
    );

    assign per_in = filt;
    assign irq    = |(isr_q & cfg[GRP_MASK]);

    // per-line output mux
    for (genvar i = 0; i < N; i++) begin : g_mux
        logic [1:0] fn;
        assign fn = {cfg[GRP_SEL1][i], cfg[GRP_SEL0][i]};
        always_comb begin
            if (gpio_q[i]) begin
                pad_out[i] = out_q[i];
                pad_oe[i]  = cfg[GRP_OE][i];
            end else begin
                pad_out[i] = per_out[int'(fn) * N + i];
                pad_oe[i]  = per_oe[int'(fn) * N + i];
            end
        end
    end

    // read port
    assign ra = addr_t'(rd_addr);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= '0;
            if (int'(ra.grp) < NGRP && ra.op == OP_VAL)
                rd_data <= cfg[ra.grp];
            else if (rd_addr == A_PIN)
                rd_data <= filt;
            else if (rd_addr == A_ISR)
                rd_data <= isr_q;
            else if (rd_addr == A_DIV)
                rd_data <= N'(div_q);
        end
    end
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
    import pio_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [N-1:0]      wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              irq,
    input logic [N-1:0]      pad_out,
    input logic [N-1:0]      out_q,
    input logic [N-1:0]      gpio_q,
    input logic [N-1:0]      isr_q
);
    a_r1_set_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 6'd0) |=> ((out_q & $past(wr_data)) == $past(wr_data)));

    a_r1_clr_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 6'd1) |=> ((out_q & $past(wr_data)) == '0));

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr[5:2] == 4'(GRP_OUT)) |=> (out_q == $past(out_q)));

    a_r2_clean_start: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (isr_q == '0 && !irq));

    a_r3_gpio_drive: assert property (@(posedge clk) disable iff (rst)
        ((pad_out ^ out_q) & gpio_q) == '0);

    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en && rd_addr == A_ISR) |-> (($past(isr_q) & ~isr_q) == '0));
endmodule

bind pio_bank pio_bank_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .irq    (irq),
    .pad_out(pad_out),
    .out_q  (out_q),
    .gpio_q (gpio_q),
    .isr_q  (isr_q)
);

// File: tb/test_pio_bank.sv
module test_pio_bank;
    localparam int N = 32;
    localparam int L = 5; // line used for input tests

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en, rd_en;
    logic [5:0]    wr_addr, rd_addr;
    logic [N-1:0]  wr_data, rd_data, pad_in, pad_out, pad_oe, per_in;
    logic [4*N-1:0] per_out, per_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pio_bank #(.N(N), .DIVW(16), .DB_TICKS(3)) i_pio_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe),
        .per_in(per_in), .irq(irq)
    );

    function automatic logic [5:0] ad(input int grp, input int op);
        return 6'(grp * 4 + op);
    endfunction

    function automatic logic [N-1:0] mux_model(input logic [N-1:0] gp, input logic [N-1:0] s0,
                                               input logic [N-1:0] s1, input logic [N-1:0] own,
                                               input logic [4*N-1:0] pv);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++)
            r[i] = gp[i] ? own[i] : pv[(2 * int'(s1[i]) + int'(s0[i])) * N + i];
        return r;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [N-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // program line L's trigger kind through set/clear writes
    task automatic set_trig(input logic alt, input logic lvl, input logic pol);
        wr(ad(8, alt ? 0 : 1), 32'(1) << L);
        wr(ad(9, lvl ? 0 : 1), 32'(1) << L);
        wr(ad(10, pol ? 0 : 1), 32'(1) << L);
    endtask

    // drive line L from 'from' to 'to' and return whether status bit L latched
    task automatic edge_test(input logic from, input logic to, output logic hit);
        logic [N-1:0] d;
        @(negedge clk); pad_in[L] = from;
        wait_cyc(10);
        rd(6'd45, d);
        rd(6'd45, d);
        @(negedge clk); pad_in[L] = to;
        wait_cyc(10);
        rd(6'd45, d);
        hit = d[L];
    endtask

    initial begin
        logic [N-1:0] d, m_out, m_oe, m_gp, m_s0, m_s1, sv, cv;
        logic         h;
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
        pad_in = '0; per_out = '0; per_oe = '0;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);

        // R2 reset state
        rd(ad(0, 2), d); check("R2 out reset", d, '0);
        rd(ad(1, 2), d); check("R2 oe reset", d, '0);
        rd(ad(2, 2), d); check("R2 gpio reset", d, '1);
        rd(ad(7, 2), d); check("R2 mask reset", d, '0);
        rd(6'd45, d);    check("R2 status reset", d, '0);
        check("R2 irq reset", 32'(irq), 32'(0));

        // R1 / R3 random set-clear traffic on output value and enable
        m_out = '0; m_oe = '0;
        for (int k = 0; k < 40; k++) begin
            sv = $urandom; cv = $urandom;
            if (k == 0) sv = '0; // writing zeros must change nothing
            if ($urandom_range(1)) begin
                wr(ad(0, 0), sv); m_out = m_out | sv;
                wr(ad(0, 1), cv); m_out = m_out & ~cv;
            end else begin
                wr(ad(1, 0), sv); m_oe = m_oe | sv;
                wr(ad(1, 1), cv); m_oe = m_oe & ~cv;
            end
            rd(ad(0, 2), d); check("R1 out readback", d, m_out);
            rd(ad(1, 2), d); check("R1 oe readback", d, m_oe);
            check("R3 pad_out gpio", pad_out, m_out);
            check("R3 pad_oe gpio", pad_oe, m_oe);
        end

        // R4 peripheral mux with random assignment
        m_gp = '1; m_s0 = '0; m_s1 = '0;
        for (int k = 0; k < 20; k++) begin
            cv = $urandom; wr(ad(2, 1), cv); m_gp = m_gp & ~cv;
            sv = $urandom; wr(ad(2, 0), sv); m_gp = m_gp | sv;
            sv = $urandom; wr(ad(3, 0), sv); m_s0 = m_s0 | sv;
            cv = $urandom; wr(ad(3, 1), cv); m_s0 = m_s0 & ~cv;
            sv = $urandom; wr(ad(4, 0), sv); m_s1 = m_s1 | sv;
            cv = $urandom; wr(ad(4, 1), cv); m_s1 = m_s1 & ~cv;
            @(negedge clk);
            per_out = {$urandom, $urandom, $urandom, $urandom};
            per_oe  = {$urandom, $urandom, $urandom, $urandom};
            #1;
            check("R4 pad_out mux", pad_out, mux_model(m_gp, m_s0, m_s1, m_out, per_out));
            check("R4 pad_oe mux", pad_oe, mux_model(m_gp, m_s0, m_s1, m_oe, per_oe));
        end
        // directed: all lines on function 3
        wr(ad(2, 1), '1); wr(ad(3, 0), '1); wr(ad(4, 0), '1);
        @(negedge clk); #1;
        check("R4 function 3 lane", pad_out, per_out[4*N-1:3*N]);
        wr(ad(2, 0), '1);

        // R5 unfiltered pin data follows pads after synchronizer
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); pad_in = $urandom;
            wait_cyc(3);
            rd(6'd44, d); check("R5 pin data", d, pad_in);
            check("R5 per_in", per_in, pad_in);
        end
        @(negedge clk); pad_in = '0;
        wait_cyc(4);
        wr(ad(7, 0), 32'(1) << L);

        // R8 any change, both directions
        set_trig(1'b0, 1'b0, 1'b0);
        edge_test(1'b0, 1'b1, h); check("R8 any rise", 32'(h), 32'(1));
        edge_test(1'b1, 1'b0, h); check("R8 any fall", 32'(h), 32'(1));

        // R9 rising / falling only
        set_trig(1'b1, 1'b0, 1'b1);
        edge_test(1'b1, 1'b0, h); check("R9 rise ignores fall", 32'(h), 32'(0));
        edge_test(1'b0, 1'b1, h); check("R9 rise", 32'(h), 32'(1));
        rd(6'd45, d); check("R9 edge latched once", 32'(d[L]), 32'(0));
        set_trig(1'b1, 1'b0, 1'b0);
        edge_test(1'b0, 1'b1, h); check("R9 fall ignores rise", 32'(h), 32'(0));
        edge_test(1'b1, 1'b0, h); check("R9 fall", 32'(h), 32'(1));

        // R10 levels, re-latched while held
        set_trig(1'b1, 1'b1, 1'b0);
        edge_test(1'b1, 1'b0, h); check("R10 low level", 32'(h), 32'(1));
        rd(6'd45, d); check("R10 low relatch", 32'(d[L]), 32'(1));
        set_trig(1'b1, 1'b1, 1'b1);
        edge_test(1'b0, 1'b1, h); check("R10 high level", 32'(h), 32'(1));
        rd(6'd45, d); check("R10 high relatch", 32'(d[L]), 32'(1));

        // R11 / R12 status clear-on-read and mask
        set_trig(1'b1, 1'b0, 1'b1);
        @(negedge clk); pad_in[L] = 1'b0; wait_cyc(8);
        rd(6'd45, d);
        @(negedge clk); pad_in[L] = 1'b1; wait_cyc(8);
        check("R12 irq on masked-in event", 32'(irq), 32'(1));
        rd(6'd45, d); check("R11 status read", 32'(d[L]), 32'(1));
        @(negedge clk);
        check("R11 cleared irq", 32'(irq), 32'(0));
        rd(6'd45, d); check("R11 cleared status", 32'(d[L]), 32'(0));
        wr(ad(7, 1), 32'(1) << L);
        @(negedge clk); pad_in[L] = 1'b0; wait_cyc(3);
        @(negedge clk); pad_in[L] = 1'b1; wait_cyc(8);
        check("R12 masked no irq", 32'(irq), 32'(0));
        rd(6'd45, d); check("R12 masked still latched", 32'(d[L]), 32'(1));

        // R6 glitch filter, any-change mode
        set_trig(1'b0, 1'b0, 1'b0);
        wr(ad(5, 0), 32'(1) << L); wr(ad(6, 1), 32'(1) << L);
        @(negedge clk); pad_in[L] = 1'b0; wait_cyc(8);
        rd(6'd45, d);
        @(negedge clk); pad_in[L] = 1'b1;
        @(negedge clk); pad_in[L] = 1'b0;
        wait_cyc(8);
        rd(6'd45, d); check("R6 one-cycle pulse rejected", 32'(d[L]), 32'(0));
        rd(6'd44, d); check("R6 pin data low", 32'(d[L]), 32'(0));
        @(negedge clk); pad_in[L] = 1'b1;
        wait_cyc(2);
        @(negedge clk); pad_in[L] = 1'b0;
        wait_cyc(8);
        rd(6'd45, d); check("R6 two-cycle pulse accepted", 32'(d[L]), 32'(1));

        // R7 debounce, divider period 4, three ticks
        wr(6'd46, 32'd3);
        wr(ad(6, 0), 32'(1) << L);
        wait_cyc(30);
        rd(6'd45, d);
        @(negedge clk); pad_in[L] = 1'b1;
        wait_cyc(4);
        @(negedge clk); pad_in[L] = 1'b0;
        wait_cyc(30);
        rd(6'd45, d); check("R7 short pulse rejected", 32'(d[L]), 32'(0));
        @(negedge clk); pad_in[L] = 1'b1;
        wait_cyc(30);
        rd(6'd44, d); check("R7 held level accepted", 32'(d[L]), 32'(1));
        rd(6'd45, d); check("R7 change latched", 32'(d[L]), 32'(1));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule